// File: doc/BRIEF.md
# FIFO Channel Reset and Retransmit Sequencer

This block sequences the reset behaviour of one synchronous FIFO channel. It has three control inputs that may change at any time relative to the clock. The first is a master reset. The second is a shared input that acts as either a partial reset or a retransmit, depending on a mode select pin. The third is a chip-level power-on reset for the block's own flops. Each asynchronous request input passes through a multi-flop synchroniser. A low-time counter then filters it, so a request only takes effect after the synchronised input has been low for at least `MIN_LOW` rising clock edges. Shorter pulses are ignored.

While a qualified reset is held, the block asserts the write-pointer and read-pointer clear outputs. It also drives the flag outputs to their reset values and raises `flag_force`, which tells downstream flag logic that these values are authoritative. When the reset is released, the block waits `ARM_CYC` clock cycles and then raises `in_ready`. In that same cycle it gives a single-cycle `ready` pulse.

The release of a master reset captures the configuration straps: endian select and the flag-offset method select. A partial reset leaves the captured configuration untouched. A retransmit clears only the read pointer, and the write side keeps running.

The sequencer has six states. Each transition is listed below.

- `ST_POWERUP`: the state after the power-on reset. It goes to `ST_MRST` on a qualified master reset (*mrst_enter*).
- `ST_MRST`: the master reset is held. It goes to `ST_ARM` on master release and captures the straps (*mrst_leave*).
- `ST_PRST`: the partial reset is held. It goes to `ST_ARM` on shared release (*prst_leave*).
- `ST_RTX`: the retransmit is held. It goes back to `ST_RUN` on shared release (*rtx_leave*).
- `ST_ARM`: the post-reset wait. It goes to `ST_RUN` after `ARM_CYC` cycles (*arm_done*). It goes to `ST_PRST` on a qualified partial reset (*prst_enter*).
- `ST_RUN`: normal operation. It goes to `ST_PRST` on a qualified shared request while `rt_sel` is low (*prst_enter*). It goes to `ST_RTX` on a qualified shared request while `rt_sel` is high (*rtx_enter*).

A qualified master reset moves every state to `ST_MRST` (*mrst_enter*). Master reset therefore has priority over everything else.

Top module: `fifo_rst_seq`

## Requirements
- R1: A request on `mrst_n` or `aux_rst_n` takes effect only if the synchronised input stays low for at least 4 rising edges (`MIN_LOW`=4). A pin driven low for 3 clock periods causes no pointer clear and does not change `in_ready`. A pin driven low for exactly 4 periods is accepted.
- R2: A qualified master reset shows at the outputs 7 clock cycles after the pin falls. From then on, `wr_ptr_clr`=1 and `rd_ptr_clr`=1. The flag outputs are `in_ready`=0, `out_ready`=0, `almost_empty`=0, `almost_full`=1 and `mbox_flag`=1, with `flag_force`=1. This holds until 4 cycles after the pin rises.
- R3: After a master or partial reset is released, `in_ready` rises exactly 6 cycles after the pin rises. The release itself is seen 4 cycles after the pin rises, so the rise follows 2 cycles (`ARM_CYC`) of waiting after release. `ready` is high for exactly the one cycle in which `in_ready` rises.
- R4: On master release, `cfg_endian` and `cfg_fsel` take the values of `strap_endian` and `strap_fsel`. They become visible 4 cycles after `mrst_n` rises.
- R5: When `rt_sel`=0, a qualified `aux_rst_n` request is a partial reset. It clears both pointers and drives the same flag reset values as R2, and `cfg_endian` and `cfg_fsel` are left unchanged.
- R6: When `rt_sel`=1, a qualified `aux_rst_n` request is a retransmit. Only `rd_ptr_clr` is asserted. `in_ready` stays 1, and `wr_ptr_clr`, `flag_force` and `ready` stay 0. `rd_ptr_clr` drops 4 cycles after the pin rises, and `ready` does not pulse.
- R7: `aux_rst_n` requests are ignored in `ST_POWERUP` and while a master reset is held. After the master release, the timing of R3 applies unchanged.
- R8: After the power-on reset, the block is in `ST_POWERUP`. The flags are at the R2 reset values with `flag_force`=1. Both pointer clears are 0, `ready`=0, and the configuration is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| por_n | input | 1 | Power-on reset for the block's own flops, active low |
| mrst_n | input | 1 | Master reset request, active low, asynchronous |
| aux_rst_n | input | 1 | Shared partial-reset / retransmit request, active low, asynchronous |
| rt_sel | input | 1 | 1: shared input acts as retransmit; 0: shared input acts as partial reset |
| strap_endian | input | 1 | Endian select strap, captured at master release |
| strap_fsel | input | 3 | Flag-offset method select straps, captured at master release |
| wr_ptr_clr | output | 1 | Hold the write pointer at the first location |
| rd_ptr_clr | output | 1 | Hold the read pointer at the first location |
| in_ready | output | 1 | Full / input-ready flag, high when writes may be accepted |
| out_ready | output | 1 | Empty / output-ready flag value forced during reset |
| almost_empty | output | 1 | Almost-empty flag value forced during reset |
| almost_full | output | 1 | Almost-full flag value forced during reset |
| mbox_flag | output | 1 | Mailbox flag value forced during reset |
| flag_force | output | 1 | Flag outputs are authoritative reset values |
| ready | output | 1 | One-cycle pulse when the channel becomes writable |
| cfg_endian | output | 1 | Captured endian select |
| cfg_fsel | output | 3 | Captured flag-offset method select |

## Verification
A wrong internal state shows up at the ports as a shift in the cycle where a pointer clear or `in_ready` changes, measured from the pin edge. Examples are a low-time counter that qualifies one edge early or late, or an arm counter that ends too soon. Because every expectation is tied to an exact cycle after the pin edge, an off-by-one in any stage shows up within about 7 cycles. A mis-routed shared request shows up at once as a wrong mix of `wr_ptr_clr`, `rd_ptr_clr` and `in_ready`. An unwanted strap capture shows up as changed `cfg_*` values after a partial reset. A master reset that does not dominate shows up as early pointer release or a wrong capture time.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    parameter int unsigned RSQ_FSEL_W = 3;

    typedef enum logic [2:0] {
        ST_POWERUP = 3'd0,
        ST_MRST    = 3'd1,
        ST_PRST    = 3'd2,
        ST_RTX     = 3'd3,
        ST_ARM     = 3'd4,
        ST_RUN     = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic                  endian;
        logic [RSQ_FSEL_W-1:0] fsel;
    } seq_cfg_t;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_n};
        end
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_lowqual.sv
module rsq_lowqual #(
    parameter int unsigned MIN_LOW = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic sync_n,
    output logic active,
    output logic release_p
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt_q;
    logic          rel_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt_q <= '0;
            rel_q     <= 1'b0;
        end else begin
            rel_q <= sync_n && (low_cnt_q == CMAX);
            if (sync_n) begin
                low_cnt_q <= '0;
            end else if (low_cnt_q != CMAX) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign active    = (low_cnt_q == CMAX);
    assign release_p = rel_q;

    // Qualification only follows a synchronised low level (R1)
    assert_qual_after_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(active) |-> $past(!sync_n));

    // A release can only follow a qualified request (R1)
    assert_release_after_active_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(release_p) |-> $past(active));
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int unsigned ARM_CYC = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  m_act,
    input  logic                  m_rel,
    input  logic                  a_act,
    input  logic                  a_rel,
    input  logic                  rt_sel,
    input  logic                  strap_endian,
    input  logic [RSQ_FSEL_W-1:0] strap_fsel,
    output logic                  wr_ptr_clr,
    output logic                  rd_ptr_clr,
    output logic                  in_ready,
    output logic                  out_ready,
    output logic                  almost_empty,
    output logic                  almost_full,
    output logic                  mbox_flag,
    output logic                  flag_force,
    output logic                  ready,
    output logic                  cfg_endian,
    output logic [RSQ_FSEL_W-1:0] cfg_fsel
);
    localparam int unsigned AW = (ARM_CYC > 1) ? $clog2(ARM_CYC) : 1;
    localparam logic [AW-1:0] ARM_LAST = AW'(ARM_CYC - 1);

    seq_state_e state_q, state_d;
    logic [AW-1:0] arm_cnt_q;
    seq_cfg_t  cfg_q;
    logic      ready_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (m_act) begin
            state_d = ST_MRST;                        // mrst_enter
        end else begin
            unique case (state_q)
                ST_POWERUP: state_d = ST_POWERUP;
                ST_MRST:    if (m_rel) state_d = ST_ARM;   // mrst_leave
                ST_PRST:    if (a_rel) state_d = ST_ARM;   // prst_leave
                ST_RTX:     if (a_rel) state_d = ST_RUN;   // rtx_leave
                ST_ARM: begin
                    if (a_act && !rt_sel)          state_d = ST_PRST; // prst_enter
                    else if (arm_cnt_q == ARM_LAST) state_d = ST_RUN; // arm_done
                end
                ST_RUN: begin
                    if (a_act && !rt_sel)     state_d = ST_PRST;  // prst_enter
                    else if (a_act && rt_sel) state_d = ST_RTX;   // rtx_enter
                end
                default:    state_d = ST_POWERUP;
            endcase
        end
    end

    // state register, arm counter, strap capture, ready pulse
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q   <= ST_POWERUP;
            arm_cnt_q <= '0;
            cfg_q     <= '0;
            ready_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            arm_cnt_q <= (state_q == ST_ARM && state_d == ST_ARM) ? arm_cnt_q + 1'b1 : '0;
            if (state_q == ST_MRST && state_d == ST_ARM) begin
                cfg_q.endian <= strap_endian;
                cfg_q.fsel   <= strap_fsel;
            end
            ready_q <= (state_q == ST_ARM) && (state_d == ST_RUN);
        end
    end

    // outputs per state
    always_comb begin
        wr_ptr_clr   = 1'b0;
        rd_ptr_clr   = 1'b0;
        in_ready     = 1'b0;
        out_ready    = 1'b0;
        almost_empty = 1'b0;
        almost_full  = 1'b1;
        mbox_flag    = 1'b1;
        flag_force   = 1'b1;
        unique case (state_q)
            ST_POWERUP: ;
            ST_MRST, ST_PRST: begin
                wr_ptr_clr = 1'b1;
                rd_ptr_clr = 1'b1;
            end
            ST_ARM: ;
            ST_RTX: begin
                rd_ptr_clr = 1'b1;
                in_ready   = 1'b1;
                flag_force = 1'b0;
            end
            ST_RUN: begin
                in_ready   = 1'b1;
                flag_force = 1'b0;
            end
            default: ;
        endcase
    end

    assign ready      = ready_q;
    assign cfg_endian = cfg_q.endian;
    assign cfg_fsel   = cfg_q.fsel;

    assert_reset_flags_R2: assert property (@(posedge clk) disable iff (!por_n)
        wr_ptr_clr |-> (!in_ready && almost_full && mbox_flag && flag_force && rd_ptr_clr));

    assert_arm_wait_R3: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(in_ready) && !$past(rd_ptr_clr)) |-> ($past(state_q == ST_ARM) && $past(state_q == ST_ARM, 2)));

    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!por_n)
        ready |-> (in_ready && !$past(in_ready)));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_MRST) |=> $stable(cfg_q));

    assert_rtx_write_side_R6: assert property (@(posedge clk) disable iff (!por_n)
        (rd_ptr_clr && !wr_ptr_clr) |-> (in_ready && !flag_force && !ready));

    assert_master_dominates_R7: assert property (@(posedge clk) disable iff (!por_n)
        m_act |=> (state_q == ST_MRST));
endmodule

// File: rtl/fifo_rst_seq.sv
module fifo_rst_seq
    import rsq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 4,
    parameter int unsigned ARM_CYC     = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  mrst_n,
    input  logic                  aux_rst_n,
    input  logic                  rt_sel,
    input  logic                  strap_endian,
    input  logic [RSQ_FSEL_W-1:0] strap_fsel,
    output logic                  wr_ptr_clr,
    output logic                  rd_ptr_clr,
    output logic                  in_ready,
    output logic                  out_ready,
    output logic                  almost_empty,
    output logic                  almost_full,
    output logic                  mbox_flag,
    output logic                  flag_force,
    output logic                  ready,
    output logic                  cfg_endian,
    output logic [RSQ_FSEL_W-1:0] cfg_fsel
);
    localparam int unsigned NREQ = 2;   // index 0: master, 1: shared

    logic [NREQ-1:0] raw_n, sync_n, act, rel;

    assign raw_n = {aux_rst_n, mrst_n};

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .por_n   (por_n),
            .async_n (raw_n[g]),
            .sync_n  (sync_n[g])
        );
        rsq_lowqual #(.MIN_LOW(MIN_LOW)) u_qual (
            .clk       (clk),
            .por_n     (por_n),
            .sync_n    (sync_n[g]),
            .active    (act[g]),
            .release_p (rel[g])
        );
    end

    rsq_fsm #(.ARM_CYC(ARM_CYC)) u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .m_act        (act[0]),
        .m_rel        (rel[0]),
        .a_act        (act[1]),
        .a_rel        (rel[1]),
        .rt_sel       (rt_sel),
        .strap_endian (strap_endian),
        .strap_fsel   (strap_fsel),
        .wr_ptr_clr   (wr_ptr_clr),
        .rd_ptr_clr   (rd_ptr_clr),
        .in_ready     (in_ready),
        .out_ready    (out_ready),
        .almost_empty (almost_empty),
        .almost_full  (almost_full),
        .mbox_flag    (mbox_flag),
        .flag_force   (flag_force),
        .ready        (ready),
        .cfg_endian   (cfg_endian),
        .cfg_fsel     (cfg_fsel)
    );
endmodule

// File: tb/tb_fifo_rst_seq.sv
module tb_fifo_rst_seq;
    logic       clk = 1'b0;
    logic       por_n, mrst_n, aux_rst_n, rt_sel, strap_endian;
    logic [2:0] strap_fsel;
    logic       wr_ptr_clr, rd_ptr_clr, in_ready, out_ready, almost_empty;
    logic       almost_full, mbox_flag, flag_force, ready, cfg_endian;
    logic [2:0] cfg_fsel;

    fifo_rst_seq dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .aux_rst_n(aux_rst_n),
        .rt_sel(rt_sel), .strap_endian(strap_endian), .strap_fsel(strap_fsel),
        .wr_ptr_clr(wr_ptr_clr), .rd_ptr_clr(rd_ptr_clr), .in_ready(in_ready),
        .out_ready(out_ready), .almost_empty(almost_empty), .almost_full(almost_full),
        .mbox_flag(mbox_flag), .flag_force(flag_force), .ready(ready),
        .cfg_endian(cfg_endian), .cfg_fsel(cfg_fsel)
    );

    always #10 clk = ~clk;   // 50 MHz

    // observed vector bit positions
    localparam logic [12:0] IR  = 13'h0001, ORY = 13'h0002, AE = 13'h0004, AF = 13'h0008;
    localparam logic [12:0] MB  = 13'h0010, RDY = 13'h0020, WPC = 13'h0040, RPC = 13'h0080;
    localparam logic [12:0] FRC = 13'h0100, CFG = 13'h1E00;
    localparam logic [12:0] FLG  = IR | ORY | AE | AF | MB | FRC;
    localparam logic [12:0] RSTV = AF | MB | FRC;

    wire [12:0] obs = {cfg_fsel, cfg_endian, flag_force, rd_ptr_clr, wr_ptr_clr,
                       ready, mbox_flag, almost_full, almost_empty, out_ready, in_ready};

    function automatic logic [12:0] cfgv(input logic e, input logic [2:0] f);
        return {f, e, 9'd0};
    endfunction

    typedef struct {
        int          at;
        logic [12:0] mask;
        logic [12:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;

    // driver side: push an expectation dly negedges ahead
    task automatic expect_at(input int dly, input logic [12:0] m, input logic [12:0] v, input string r);
        exp_t e;
        e.at = cyc + dly; e.mask = m; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // monitor: pop and compare due expectations
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                total = total + 1;
                if ((obs & q[i].mask) !== q[i].val) begin
                    bad = bad + 1;
                    $display("FAIL %s cyc=%0d actual=%h expected=%h mask=%h",
                             q[i].req, cyc, obs & q[i].mask, q[i].val, q[i].mask);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad   = bad + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por_n = 1'b0; mrst_n = 1'b1; aux_rst_n = 1'b1; rt_sel = 1'b0;
        strap_endian = 1'b0; strap_fsel = 3'd0;
        step(3);
        por_n = 1'b1;
        step(1);
        // R8: power-up state
        expect_at(1, FLG | WPC | RPC | RDY | CFG, RSTV, "R8");
        expect_at(3, FLG | WPC | RPC | RDY | CFG, RSTV, "R8");
        step(4);

        // R1: 3-cycle master pulse ignored
        mrst_n = 1'b0; step(3); mrst_n = 1'b1;
        expect_at(4, WPC | RPC, 13'd0, "R1");
        expect_at(8, IR | WPC, 13'd0, "R1");
        step(12);

        // R7: shared request ignored before any master reset
        aux_rst_n = 1'b0;
        expect_at(7, WPC | RPC, 13'd0, "R7");
        step(6); aux_rst_n = 1'b1;
        expect_at(7, IR | WPC, 13'd0, "R7");
        step(10);

        // R2/R3/R4: full master reset
        strap_endian = 1'b1; strap_fsel = 3'd5;
        step(1);
        mrst_n = 1'b0;
        expect_at(6, WPC, 13'd0, "R2");
        expect_at(7, FLG | WPC | RPC, RSTV | WPC | RPC, "R2");
        step(10);
        mrst_n = 1'b1;
        expect_at(3, CFG, 13'd0, "R4");
        expect_at(3, WPC, WPC, "R2");
        expect_at(4, CFG, cfgv(1'b1, 3'd5), "R4");
        expect_at(4, WPC | RPC, 13'd0, "R2");
        expect_at(5, IR | RDY, 13'd0, "R3");
        expect_at(6, IR | RDY | FRC, IR | RDY, "R3");
        expect_at(7, IR | RDY, IR, "R3");
        step(8);
        strap_endian = 1'b0; strap_fsel = 3'd2;
        step(2);

        // R1: 3-cycle shared pulse in run ignored
        aux_rst_n = 1'b0; step(3); aux_rst_n = 1'b1;
        expect_at(6, IR | WPC | RPC | FRC, IR, "R1");
        expect_at(10, IR | WPC | RPC | FRC, IR, "R1");
        step(12);

        // R5: partial reset keeps configuration
        aux_rst_n = 1'b0;
        expect_at(7, FLG | WPC | RPC | CFG, RSTV | WPC | RPC | cfgv(1'b1, 3'd5), "R5");
        step(5);
        aux_rst_n = 1'b1;
        expect_at(5, IR, 13'd0, "R5");
        expect_at(6, IR | RDY | CFG, IR | RDY | cfgv(1'b1, 3'd5), "R5");
        step(10);

        // R6: retransmit clears read side only
        rt_sel = 1'b1;
        step(1);
        aux_rst_n = 1'b0;
        expect_at(6, RPC, 13'd0, "R6");
        expect_at(7, IR | WPC | RPC | FRC | RDY, IR | RPC, "R6");
        step(6);
        aux_rst_n = 1'b1;
        expect_at(3, RPC, RPC, "R6");
        expect_at(4, IR | RPC | RDY | FRC, IR, "R6");
        expect_at(6, RDY | IR, IR, "R6");
        step(8);
        rt_sel = 1'b0;
        step(1);

        // R7: master dominates an overlapping partial request
        mrst_n = 1'b0;
        step(2);
        aux_rst_n = 1'b0;
        step(10);
        aux_rst_n = 1'b1;
        expect_at(6, WPC | IR, WPC, "R7");
        step(8);
        mrst_n = 1'b1;
        expect_at(4, CFG, cfgv(1'b0, 3'd2), "R4");
        expect_at(5, IR, 13'd0, "R7");
        expect_at(6, IR | RDY, IR | RDY, "R7");
        step(10);

        // R1 boundary: exactly 4 low cycles accepted
        strap_endian = 1'b1; strap_fsel = 3'd3;
        step(1);
        mrst_n = 1'b0;
        step(4);
        mrst_n = 1'b1;
        expect_at(3, WPC | RPC, WPC | RPC, "R1");
        expect_at(4, WPC | CFG, cfgv(1'b1, 3'd3), "R4");
        expect_at(6, IR | RDY, IR | RDY, "R3");
        step(12);

        if (q.size() != 0) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule